// File: doc/BRIEF.md
# Bus Access Watchdog and Board Status Lights

This block supervises the accesses a processor board makes to its external system bus and to its expansion-module bus. Each access start arms a single cycle-counting window. If no acknowledge arrives before the window closes, the block issues a one-cycle forced ready that ends the stalled processor cycle. It also raises a level interrupt request and lights a timeout indicator that stays on until software clears it.

The same block drives three more indicators. The parity indicator latches any on-board or system-bus parity-error strobe. The activity indicator is retriggered by every processor bus-cycle start and goes dark once cycles stop for a programmable hold time. The user indicator follows a bit that software writes to one decoded register address. Either of two active-low reset inputs (auxiliary or init) clears every register. The reset is applied asynchronously and released on the clock.

Top module: `bus_supervisor`

## Requirements
- R1: While `aux_rst_n` or `init_rst_n` is low, and after a reset, `force_rdy`, `irq` and all four indicators are 0. A reset during a pending access abandons it, so no `force_rdy` follows.
- R2: If `acc_start` is sampled at clock edge E0 and neither `acc_ack` nor another `acc_start` is sampled afterwards, `force_rdy` is 1 for exactly the one cycle that follows edge E0+TIMEOUT_CYC.
- R3: An `acc_ack` sampled at any edge from E0+1 to E0+TIMEOUT_CYC inclusive cancels the pending access, and no `force_rdy` occurs for it.
- R4: An `acc_start` sampled while an access is pending restarts the window, which is then measured from the new start.
- R5: `led_timeout` and `irq` become 1 in the same cycle as `force_rdy` and hold at 1 until they are cleared.
- R6: A write (`reg_wr`=1, `reg_addr`=CTRL_ADDR) with bit 1 of `reg_wdata` set clears `led_timeout` and `irq`. If a timeout expires at the same edge, the timeout wins and both stay 1.
- R7: A pulse on `par_err_local` or on `par_err_sys` sets `led_parity`. It stays 1 until a write to CTRL_ADDR with bit 2 of `reg_wdata` set.
- R8: `led_active` is 1 for exactly HOLD_CYC cycles after the latest sampled `cyc_start`. A new `cyc_start` restarts that period.
- R9: A write to CTRL_ADDR loads bit 0 of `reg_wdata` into `led_user`. Writes to any other address have no effect on `led_user`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| aux_rst_n | input | 1 | Auxiliary reset, active low |
| init_rst_n | input | 1 | Init reset from another board, active low |
| acc_start | input | 1 | One-cycle pulse: an access to the system or expansion bus begins |
| acc_ack | input | 1 | One-cycle pulse: the addressed device acknowledged |
| par_err_local | input | 1 | On-board parity-error strobe |
| par_err_sys | input | 1 | System-bus parity-error strobe |
| cyc_start | input | 1 | Processor bus-cycle start pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register write address |
| reg_wdata | input | 3 | Write data: bit0 user light, bit1 clear timeout, bit2 clear parity |
| force_rdy | output | 1 | One-cycle forced ready that aborts a stalled access |
| irq | output | 1 | Timeout interrupt request, level |
| led_timeout | output | 1 | Bus timeout indicator |
| led_parity | output | 1 | Parity error indicator |
| led_active | output | 1 | Processor activity indicator |
| led_user | output | 1 | Software-controlled indicator |

## Verification
The bench builds the block with TIMEOUT_CYC=40 and HOLD_CYC=12 in place of the real-time defaults. With these values the exact expiry edge, an acknowledge at the very last edge of the window, a restart in mid-window and the full decay of the activity light each take a few dozen cycles. A scoreboard predicts the cycle of every forced ready from the stimulus and treats any forced ready it did not predict as an error. The collision between a clear write and an expiry at the same edge is also driven.

// File: rtl/bsup_pkg.sv
package bsup_pkg;
  localparam int unsigned CTRL_W       = 3;
  localparam int unsigned BIT_USER     = 0;
  localparam int unsigned BIT_CLR_TO   = 1;
  localparam int unsigned BIT_CLR_PAR  = 2;

  typedef struct packed {
    logic user_wr;
    logic user_val;
    logic clr_to;
    logic clr_par;
  } bsup_cmd_t;
endpackage

// File: rtl/bsup_rst_sync.sv
module bsup_rst_sync (
  input  logic clk,
  input  logic aux_rst_n,
  input  logic init_rst_n,
  output logic rst_n
);
  logic raw_n;
  logic [1:0] sync_q;

  assign raw_n = aux_rst_n & init_rst_n;

  always_ff @(posedge clk or negedge raw_n) begin
    if (!raw_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/bsup_access_timer.sv
module bsup_access_timer #(
  parameter int unsigned TIMEOUT_CYC = 160000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_start,
  input  logic acc_ack,
  output logic expire,
  output logic force_rdy
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (acc_start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (acc_ack) begin
        busy_d = 1'b0;
      end else if (cnt_q == LAST) begin
        busy_d = 1'b0;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    rdy_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (busy_d) cnt_q <= cnt_d;
      rdy_q  <= rdy_d;
    end
  end

  assign force_rdy = rdy_q;

  a_r2_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    force_rdy |=> !force_rdy);
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
  a_r3_ack_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && acc_ack && !acc_start) |=> (!busy_q && !force_rdy));
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (busy_q && cnt_q == '0 && !force_rdy));
endmodule

// File: rtl/bsup_activity.sv
module bsup_activity #(
  parameter int unsigned HOLD_CYC = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  output logic led_active
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD = HW'(HOLD_CYC);

  logic [HW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (cyc_start) begin
      hold_d  = HOLD;
      hold_en = 1'b1;
    end else if (hold_q != '0) begin
      hold_d  = hold_q - 1'b1;
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign led_active = (hold_q != '0);

  a_r8_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (led_active && hold_q == HOLD));
  a_r8_stays_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_active && !cyc_start) |=> !led_active);
endmodule

// File: rtl/bsup_status.sv
module bsup_status
  import bsup_pkg::*;
#(
  parameter int unsigned REG_AW    = 8,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              par_err_local,
  input  logic              par_err_sys,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic              led_timeout,
  output logic              led_parity,
  output logic              led_user,
  output logic              irq
);
  bsup_cmd_t cmd;
  logic hit;
  logic to_q, to_d, par_q, par_d, usr_q, irq_q, irq_d;
  logic to_en, par_en, irq_en;

  always_comb begin
    hit          = reg_wr && (reg_addr == CTRL_ADDR);
    cmd.user_wr  = hit;
    cmd.user_val = reg_wdata[BIT_USER];
    cmd.clr_to   = hit && reg_wdata[BIT_CLR_TO];
    cmd.clr_par  = hit && reg_wdata[BIT_CLR_PAR];
  end

  always_comb begin
    to_en  = expire | cmd.clr_to;
    to_d   = expire;
    irq_en = expire | cmd.clr_to;
    irq_d  = expire;
    par_en = par_err_local | par_err_sys | cmd.clr_par;
    par_d  = par_err_local | par_err_sys;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q  <= 1'b0;
      irq_q <= 1'b0;
      par_q <= 1'b0;
      usr_q <= 1'b0;
    end else begin
      if (to_en)       to_q  <= to_d;
      if (irq_en)      irq_q <= irq_d;
      if (par_en)      par_q <= par_d;
      if (cmd.user_wr) usr_q <= cmd.user_val;
    end
  end

  assign led_timeout = to_q;
  assign irq         = irq_q;
  assign led_parity  = par_q;
  assign led_user    = usr_q;

  a_r6_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (led_timeout && irq));
  a_r5_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == CTRL_ADDR && reg_wdata[BIT_CLR_TO])) |=> irq);
  a_r7_parity_set: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_local || par_err_sys) |=> led_parity);
  a_r9_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != CTRL_ADDR) |=> $stable(led_user));
endmodule

// File: rtl/bus_supervisor.sv
module bus_supervisor
  import bsup_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 160000,
  parameter int unsigned HOLD_CYC    = 16000,
  parameter int unsigned REG_AW      = 8,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 8'h5C
) (
  input  logic              clk,
  input  logic              aux_rst_n,
  input  logic              init_rst_n,
  input  logic              acc_start,
  input  logic              acc_ack,
  input  logic              par_err_local,
  input  logic              par_err_sys,
  input  logic              cyc_start,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic              force_rdy,
  output logic              irq,
  output logic              led_timeout,
  output logic              led_parity,
  output logic              led_active,
  output logic              led_user
);
  logic rst_n;
  logic expire;

  bsup_rst_sync u_rst (
    .clk        (clk),
    .aux_rst_n  (aux_rst_n),
    .init_rst_n (init_rst_n),
    .rst_n      (rst_n)
  );

  bsup_access_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_start (acc_start),
    .acc_ack   (acc_ack),
    .expire    (expire),
    .force_rdy (force_rdy)
  );

  bsup_activity #(.HOLD_CYC(HOLD_CYC)) u_act (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .led_active (led_active)
  );

  bsup_status #(.REG_AW(REG_AW), .CTRL_ADDR(CTRL_ADDR)) u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .expire        (expire),
    .par_err_local (par_err_local),
    .par_err_sys   (par_err_sys),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .led_timeout   (led_timeout),
    .led_parity    (led_parity),
    .led_user      (led_user),
    .irq           (irq)
  );

  a_r5_rdy_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    force_rdy |-> (led_timeout && irq));
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    $fell(rst_n) |=> (!force_rdy && !irq && !led_timeout && !led_parity && !led_active && !led_user));
endmodule

// File: tb/bus_supervisor_tb_top.sv
`timescale 1ns/1ps
module bus_supervisor_tb_top;
  localparam int unsigned LIM  = 40;
  localparam int unsigned HOLD = 12;
  localparam logic [7:0] CADDR = 8'h5C;

  logic clk = 1'b0;
  logic aux_rst_n, init_rst_n, acc_start, acc_ack, par_err_local, par_err_sys, cyc_start, reg_wr;
  logic [7:0] reg_addr;
  logic [2:0] reg_wdata;
  logic force_rdy, irq, led_timeout, led_parity, led_active, led_user;

  int checks = 0, fails = 0, cyc = 0, popped = 0;
  int exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_supervisor #(.TIMEOUT_CYC(LIM), .HOLD_CYC(HOLD), .REG_AW(8), .CTRL_ADDR(CADDR)) dut_i (
    .clk(clk), .aux_rst_n(aux_rst_n), .init_rst_n(init_rst_n), .acc_start(acc_start),
    .acc_ack(acc_ack), .par_err_local(par_err_local), .par_err_sys(par_err_sys),
    .cyc_start(cyc_start), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .force_rdy(force_rdy), .irq(irq), .led_timeout(led_timeout), .led_parity(led_parity),
    .led_active(led_active), .led_user(led_user));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected cycle of each forced ready
  always @(negedge clk) begin
    if (!done && force_rdy === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected force_rdy", 1, 0);
      end else begin
        popped = exp_q.pop_front();
        chk("R2 force_rdy cycle", cyc, popped);
        chk("R5 led_timeout/irq with force_rdy", {led_timeout, irq}, 2'b11);
      end
    end
  end

  task automatic start_acc(input bit expect_to);
    @(negedge clk);
    acc_start = 1'b1;
    if (expect_to) exp_q.push_back(cyc + 1 + LIM);
    @(negedge clk);
    acc_start = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic act_len(output int n);
    n = 0;
    while (led_active && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    aux_rst_n = 0; init_rst_n = 1; acc_start = 0; acc_ack = 0; par_err_local = 0;
    par_err_sys = 0; cyc_start = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {force_rdy, irq, led_timeout, led_parity, led_active, led_user}, 6'b0);
    aux_rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {force_rdy, irq, led_timeout, led_parity, led_active, led_user}, 6'b0);

    // R2 plain timeout, R5 hold
    start_acc(1);
    repeat (LIM + 10) @(negedge clk);
    chk("R5 led_timeout held", led_timeout, 1);
    chk("R5 irq held", irq, 1);
    chk("R2 queue drained", exp_q.size(), 0);
    wr(8'h11, 3'b010);
    chk("R9 wrong addr no clear", led_timeout, 1);
    wr(CADDR, 3'b010);
    chk("R6 clear timeout", {led_timeout, irq}, 2'b00);

    // R3 ack at the last edge of the window
    start_acc(0);
    repeat (LIM - 1) @(negedge clk);
    acc_ack = 1'b1;
    @(negedge clk);
    acc_ack = 1'b0;
    repeat (LIM) @(negedge clk);
    chk("R3 ack at last edge cancels", {led_timeout, irq}, 2'b00);

    // R4 restart mid window
    start_acc(0);
    repeat (15) @(negedge clk);
    start_acc(1);
    repeat (LIM + 5) @(negedge clk);
    chk("R4 restart timed out once", exp_q.size(), 0);
    wr(CADDR, 3'b010);

    // R6 clear at same edge as expiry
    start_acc(1);
    repeat (LIM - 1) @(negedge clk);
    reg_wr = 1'b1; reg_addr = CADDR; reg_wdata = 3'b010;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R6 expiry wins over clear", {led_timeout, irq}, 2'b11);
    wr(CADDR, 3'b010);
    chk("R6 later clear", {led_timeout, irq}, 2'b00);

    // R7 parity
    @(negedge clk); par_err_local = 1; @(negedge clk); par_err_local = 0;
    repeat (5) @(negedge clk);
    chk("R7 local parity latched", led_parity, 1);
    wr(CADDR, 3'b100);
    chk("R7 parity cleared", led_parity, 0);
    @(negedge clk); par_err_sys = 1; @(negedge clk); par_err_sys = 0;
    chk("R7 system parity latched", led_parity, 1);

    // R8 activity
    @(negedge clk); cyc_start = 1; @(negedge clk); cyc_start = 0;
    act_len(n);
    chk("R8 activity length", n, HOLD);
    @(negedge clk); cyc_start = 1; @(negedge clk); cyc_start = 0;
    repeat (4) @(negedge clk);
    cyc_start = 1; @(negedge clk); cyc_start = 0;
    act_len(n);
    chk("R8 retriggered length", n, HOLD);

    // R9 user light
    wr(8'h5D, 3'b001);
    chk("R9 other address ignored", led_user, 0);
    wr(CADDR, 3'b001);
    chk("R9 user light on", led_user, 1);
    wr(CADDR, 3'b000);
    chk("R9 user light off", led_user, 0);
    wr(CADDR, 3'b001);

    // R1 init reset mid access
    start_acc(0);
    repeat (5) @(negedge clk);
    init_rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 init reset clears", {force_rdy, irq, led_timeout, led_parity, led_active, led_user}, 6'b0);
    init_rst_n = 1;
    repeat (LIM + 10) @(negedge clk);
    chk("R1 abandoned access silent", {irq, led_timeout}, 2'b00);
    chk("R2 no pending expectations", exp_q.size(), 0);
    finish_run();
  end
endmodule